// File: doc/BRIEF.md
# Interrupt Ring Buffer Writer

This block takes interrupt requests from on-chip clients and delivers each one to the host as a 256-bit (32-byte) record in a circular buffer in host memory. Requests wait in a small first-in first-out queue. The head request goes through three memory phases in a fixed order. First the record is written by DMA at the ring base plus the current write offset. Next the advanced write offset is published by DMA to a separately programmed shadow location. Only then is a one-cycle host interrupt raised. Only one record is in flight at a time.

Software programs the block through a 32-bit register write port. The registers hold the ring size, the ring base, the shadow address, the read and write offsets, and a doorbell setting. The host reports how far it has consumed either by writing the read-offset register or by a doorbell write. A request is held back while writing it would run the write offset into the read offset.

Top module: `irq_ring_writer`

## Requirements
- R1: While reset is low and after it is released, `dma_req_o`, `irq_o` and `err_o` are 0 and `req_ready_o` is 1. Reset empties the request queue and clears every register to zero.
- R2: Two cycles after a request is accepted on an idle block with room in the ring, a packet write is requested. It has `dma_tag_o`=1 and `dma_addr_o` = ((base_hi<<32) | (base_lo<<8)) + write offset.
- R3: Packet layout on `dma_data_o` is as follows. Bits 7:0 hold the client, 15:8 the source and 23:16 the ring id. Bits 63:32 hold the context word, 95:64 hold 0x40 and 111:96 hold 0x8000. All other bits are zero.
- R4: The write offset changes only after a packet acknowledge with tag 1. The cycle after that acknowledge, a pointer write is requested with `dma_tag_o`=2 to address (shadow_hi<<32) | shadow_lo. Its `dma_data_o` carries the new offset in bits 31:0 and zeros above.
- R5: `irq_o` is high for exactly the one cycle after the pointer write is acknowledged with tag 2, and never before.
- R6: An acknowledge whose tag does not match the current phase (or arrives when no write is pending) makes `err_o` high for one cycle, the next cycle. The pending request stays up, unchanged.
- R7: Requests are served in arrival order. `req_ready_o` is 0 while the queue is full, and a request offered then is dropped.
- R8: No new packet write starts until the interrupt of the previous request has been raised. `dma_req_o` is 0 in the interrupt cycle.
- R9: The write offset advances by 32. It becomes 0 when offset+32 is at or above the ring size register.
- R10: A request is not started while its advanced write offset would equal the read offset.
- R11: Register offsets are 0 ring size, 1 base_lo, 2 base_hi, 3 read offset, 4 write offset, 5 shadow_lo, 6 shadow_hi and 7 doorbell. A read-offset write releases a stalled request.
- R12: A doorbell register write keeps bits 25:0 as the doorbell offset, and bit 28 enables the doorbell. An enabled doorbell write whose byte address equals offset*4 loads the read offset from `db_data_i`. Doorbell writes to any other address, or while disabled, are ignored.
- R13: Register writes to offsets 8 to 15 have no effect. A write to offset 4 sets the offset used by the next packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Interrupt request offered |
| req_ready_o | output | 1 | Queue can take a request |
| req_client_i | input | 8 | Client id |
| req_source_i | input | 8 | Source id |
| req_ring_i | input | 8 | Ring id |
| req_ctx_i | input | 32 | Context word |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register offset |
| reg_wdata_i | input | 32 | Register write data |
| db_valid_i | input | 1 | Doorbell write strobe |
| db_addr_i | input | 28 | Doorbell byte address |
| db_data_i | input | 32 | Doorbell value (new read offset) |
| dma_req_o | output | 1 | DMA write request, held until acknowledged |
| dma_tag_o | output | 2 | 1 packet write, 2 pointer write |
| dma_addr_o | output | 64 | DMA byte address |
| dma_data_o | output | 256 | DMA write data |
| dma_ack_i | input | 1 | DMA write completed |
| dma_ack_tag_i | input | 2 | Tag of the completed write |
| irq_o | output | 1 | Host interrupt pulse |
| err_o | output | 1 | Unexpected completion tag pulse |

## Verification
A packet request is due on the second cycle after the request is taken: one edge enqueues it and the next edge launches it. The pointer write is due on the cycle after the packet acknowledge, and the interrupt on the cycle after the pointer acknowledge. An error pulse likewise follows a bad acknowledge by one cycle. The bench drives every input and samples every output on the falling clock edge. It checks each of these results at exactly the falling edge where it is due, and checks the edge before the packet request to confirm it is not early. Stalls and dropped inputs are checked over several idle cycles after the stimulus, before the releasing action.

// File: rtl/irq_ring_pkg.sv
package irq_ring_pkg;
  localparam int unsigned ID_W      = 8;
  localparam int unsigned CTX_W     = 32;
  localparam int unsigned PTR_W     = 32;
  localparam int unsigned ADDR_W    = 64;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned REG_AW    = 4;
  localparam int unsigned DB_OFS_W  = 26;
  localparam int unsigned DB_AW     = DB_OFS_W + 2;
  localparam int unsigned DB_EN_BIT = 28;
  localparam int unsigned PKT_W     = 256;
  localparam int unsigned PKT_BYTES = PKT_W / 8;
  localparam logic [15:0] PID_FIXED = 16'h8000;
  localparam logic [31:0] TS_LO     = 32'h0000_0040;

  typedef enum logic [1:0] {
    TAG_NONE = 2'd0,
    TAG_PKT  = 2'd1,
    TAG_PTR  = 2'd2
  } dma_tag_e;

  typedef enum logic [REG_AW-1:0] {
    REG_SIZE    = 4'd0,
    REG_BASE_LO = 4'd1,
    REG_BASE_HI = 4'd2,
    REG_RPTR    = 4'd3,
    REG_WPTR    = 4'd4,
    REG_SHD_LO  = 4'd5,
    REG_SHD_HI  = 4'd6,
    REG_DBELL   = 4'd7
  } reg_ofs_e;

  typedef struct packed {
    logic [ID_W-1:0]  client;
    logic [ID_W-1:0]  source;
    logic [ID_W-1:0]  ring;
    logic [CTX_W-1:0] ctx;
  } irq_req_t;
endpackage

// File: rtl/irq_req_fifo.sv
module irq_req_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned W     = 56
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic         full_o,
  output logic         empty_o,
  output logic [W-1:0] data_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [AW-1:0] inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign data_o  = mem_q[rd_q];

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= inc(wr_q);
      if (pop_i)  rd_q <= inc(rd_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !push_i);
  p_no_underflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> !pop_i);
endmodule

// File: rtl/irq_ring_regs.sv
module irq_ring_regs
  import irq_ring_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              db_valid_i,
  input  logic [DB_AW-1:0]  db_addr_i,
  input  logic [PTR_W-1:0]  db_data_i,
  input  logic              adv_i,
  input  logic [PTR_W-1:0]  adv_wptr_i,
  output logic [PTR_W-1:0]  ring_size_o,
  output logic [ADDR_W-1:0] base_addr_o,
  output logic [ADDR_W-1:0] shadow_addr_o,
  output logic [PTR_W-1:0]  rptr_o,
  output logic [PTR_W-1:0]  wptr_o
);
  logic [REG_W-1:0]    size_q, base_lo_q, base_hi_q, shd_lo_q, shd_hi_q;
  logic [PTR_W-1:0]    rptr_q, wptr_q;
  logic [DB_OFS_W-1:0] db_ofs_q;
  logic                db_en_q;
  logic                db_hit, wr_rptr, wr_wptr;

  assign db_hit  = db_valid_i && db_en_q && (db_addr_i == {db_ofs_q, 2'b00});
  assign wr_rptr = we_i && (addr_i == REG_RPTR);
  assign wr_wptr = we_i && (addr_i == REG_WPTR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      size_q    <= '0;
      base_lo_q <= '0;
      base_hi_q <= '0;
      shd_lo_q  <= '0;
      shd_hi_q  <= '0;
      rptr_q    <= '0;
      wptr_q    <= '0;
      db_ofs_q  <= '0;
      db_en_q   <= 1'b0;
    end else begin
      if (we_i) begin
        case (reg_ofs_e'(addr_i))
          REG_SIZE:    size_q    <= wdata_i;
          REG_BASE_LO: base_lo_q <= wdata_i;
          REG_BASE_HI: base_hi_q <= wdata_i;
          REG_SHD_LO:  shd_lo_q  <= wdata_i;
          REG_SHD_HI:  shd_hi_q  <= wdata_i;
          REG_DBELL: begin
            db_ofs_q <= wdata_i[DB_OFS_W-1:0];
            db_en_q  <= wdata_i[DB_EN_BIT];
          end
          default: ;
        endcase
      end
      // register write outranks the doorbell / sequencer update
      if (wr_rptr)     rptr_q <= wdata_i;
      else if (db_hit) rptr_q <= db_data_i;
      if (wr_wptr)     wptr_q <= wdata_i;
      else if (adv_i)  wptr_q <= adv_wptr_i;
    end
  end

  assign ring_size_o   = size_q;
  assign base_addr_o   = {base_hi_q, 32'h0} | (ADDR_W'(base_lo_q) << 8);
  assign shadow_addr_o = {shd_hi_q, shd_lo_q};
  assign rptr_o        = rptr_q;
  assign wptr_o        = wptr_q;

  p_wptr_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_wptr && !adv_i) |=> $stable(wptr_o));
  p_db_ignored_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!db_en_q && !wr_rptr) |=> $stable(rptr_o));
endmodule

// File: rtl/irq_ring_seq.sv
module irq_ring_seq
  import irq_ring_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              empty_i,
  input  irq_req_t          head_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [ADDR_W-1:0] shadow_addr_i,
  input  logic [PTR_W-1:0]  ring_size_i,
  input  logic [PTR_W-1:0]  rptr_i,
  input  logic [PTR_W-1:0]  wptr_i,
  input  logic              dma_ack_i,
  input  logic [1:0]        dma_ack_tag_i,
  output logic              pop_o,
  output logic              adv_o,
  output logic [PTR_W-1:0]  adv_wptr_o,
  output logic              dma_req_o,
  output logic [1:0]        dma_tag_o,
  output logic [ADDR_W-1:0] dma_addr_o,
  output logic [PKT_W-1:0]  dma_data_o,
  output logic              irq_o,
  output logic              err_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_PKT, ST_PTR, ST_NOTE} st_e;

  st_e          state_q, state_d;
  irq_req_t     cur_q;
  logic         err_q, good_ack, ring_full;
  logic [PTR_W:0]   sum;
  logic [PTR_W-1:0] nxt;
  logic [PKT_W-1:0] pkt;

  assign sum       = {1'b0, wptr_i} + (PTR_W+1)'(PKT_BYTES);
  assign nxt       = (sum >= {1'b0, ring_size_i}) ? '0 : sum[PTR_W-1:0];
  assign ring_full = (nxt == rptr_i);

  assign pop_o      = (state_q == ST_IDLE) && !empty_i && !ring_full;
  assign good_ack   = dma_ack_i && (dma_ack_tag_i == dma_tag_o) && dma_req_o;
  assign adv_o      = (state_q == ST_PKT) && good_ack;
  assign adv_wptr_o = nxt;

  always_comb begin
    pkt = '0;
    pkt[0 +: ID_W]      = cur_q.client;
    pkt[ID_W +: ID_W]   = cur_q.source;
    pkt[2*ID_W +: ID_W] = cur_q.ring;
    pkt[32 +: CTX_W]    = cur_q.ctx;
    pkt[64 +: 32]       = TS_LO;
    pkt[96 +: 16]       = PID_FIXED;
  end

  always_comb begin
    dma_req_o  = 1'b0;
    dma_tag_o  = TAG_NONE;
    dma_addr_o = '0;
    dma_data_o = '0;
    case (state_q)
      ST_PKT: begin
        dma_req_o  = 1'b1;
        dma_tag_o  = TAG_PKT;
        dma_addr_o = base_addr_i + ADDR_W'(wptr_i);
        dma_data_o = pkt;
      end
      ST_PTR: begin
        dma_req_o  = 1'b1;
        dma_tag_o  = TAG_PTR;
        dma_addr_o = shadow_addr_i;
        dma_data_o = PKT_W'(wptr_i);
      end
      default: ;
    endcase
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (pop_o)    state_d = ST_PKT;
      ST_PKT:  if (good_ack) state_d = ST_PTR;
      ST_PTR:  if (good_ack) state_d = ST_NOTE;
      default:               state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= dma_ack_i && !good_ack;
      if (pop_o) cur_q <= head_i;
    end
  end

  assign irq_o = (state_q == ST_NOTE);
  assign err_o = err_q;

  p_irq_after_ptr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(dma_req_o && dma_ack_i && dma_ack_tag_i == TAG_PTR));
  p_err_after_ack_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(dma_ack_i));
  p_req_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_req_o && !dma_ack_i) |=> (dma_req_o && $stable(dma_tag_o)));
  p_adv_on_ack_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_o |-> (dma_ack_i && dma_ack_tag_i == TAG_PKT));
  p_no_overrun_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o |-> (adv_wptr_o != rptr_i));
endmodule

// File: rtl/irq_ring_writer.sv
module irq_ring_writer
  import irq_ring_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ID_W-1:0]   req_client_i,
  input  logic [ID_W-1:0]   req_source_i,
  input  logic [ID_W-1:0]   req_ring_i,
  input  logic [CTX_W-1:0]  req_ctx_i,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  input  logic              db_valid_i,
  input  logic [DB_AW-1:0]  db_addr_i,
  input  logic [PTR_W-1:0]  db_data_i,
  output logic              dma_req_o,
  output logic [1:0]        dma_tag_o,
  output logic [ADDR_W-1:0] dma_addr_o,
  output logic [PKT_W-1:0]  dma_data_o,
  input  logic              dma_ack_i,
  input  logic [1:0]        dma_ack_tag_i,
  output logic              irq_o,
  output logic              err_o
);
  localparam int unsigned REQ_W = $bits(irq_req_t);

  irq_req_t         req_in, head;
  logic [REQ_W-1:0] head_bits;
  logic             full, empty, push, pop, adv;
  logic [PTR_W-1:0] adv_wptr, ring_size, rptr, wptr;
  logic [ADDR_W-1:0] base_addr, shadow_addr;

  assign req_in      = '{client: req_client_i, source: req_source_i,
                         ring: req_ring_i, ctx: req_ctx_i};
  assign push        = req_valid_i && !full;
  assign req_ready_o = !full;
  assign head        = irq_req_t'(head_bits);

  irq_req_fifo #(.DEPTH(FIFO_DEPTH), .W(REQ_W)) u_fifo (
    .clk_i, .rst_ni,
    .push_i (push),
    .data_i (REQ_W'(req_in)),
    .pop_i  (pop),
    .full_o (full),
    .empty_o(empty),
    .data_o (head_bits)
  );

  irq_ring_regs u_regs (
    .clk_i, .rst_ni,
    .we_i         (reg_we_i),
    .addr_i       (reg_addr_i),
    .wdata_i      (reg_wdata_i),
    .db_valid_i   (db_valid_i),
    .db_addr_i    (db_addr_i),
    .db_data_i    (db_data_i),
    .adv_i        (adv),
    .adv_wptr_i   (adv_wptr),
    .ring_size_o  (ring_size),
    .base_addr_o  (base_addr),
    .shadow_addr_o(shadow_addr),
    .rptr_o       (rptr),
    .wptr_o       (wptr)
  );

  irq_ring_seq u_seq (
    .clk_i, .rst_ni,
    .empty_i      (empty),
    .head_i       (head),
    .base_addr_i  (base_addr),
    .shadow_addr_i(shadow_addr),
    .ring_size_i  (ring_size),
    .rptr_i       (rptr),
    .wptr_i       (wptr),
    .dma_ack_i    (dma_ack_i),
    .dma_ack_tag_i(dma_ack_tag_i),
    .pop_o        (pop),
    .adv_o        (adv),
    .adv_wptr_o   (adv_wptr),
    .dma_req_o    (dma_req_o),
    .dma_tag_o    (dma_tag_o),
    .dma_addr_o   (dma_addr_o),
    .dma_data_o   (dma_data_o),
    .irq_o        (irq_o),
    .err_o        (err_o)
  );

  p_one_inflight_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop |-> (!dma_req_o && !irq_o));
  p_irq_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
endmodule

// File: tb/irq_ring_writer_test.sv
module irq_ring_writer_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam logic [63:0] BASE   = 64'h0000_00AB_0012_3400;
  localparam logic [63:0] SHADOW = 64'h0000_00CD_0000_1000;
  localparam logic [31:0] RSIZE  = 32'h80;
  localparam int NVEC = 5;
  // {client, source, ring, ctx}
  localparam logic [55:0] VEC [NVEC] = '{
    {8'h03, 8'hB5, 8'h00, 32'h0000_0001},
    {8'h0A, 8'h11, 8'h01, 32'hDEAD_BEEF},
    {8'hFF, 8'h00, 8'h7E, 32'h0000_0000},
    {8'h14, 8'hB5, 8'h02, 32'h1234_5678},
    {8'h00, 8'hFF, 8'hFF, 32'hFFFF_FFFF}
  };

  logic         clk = 1'b0, rst_ni = 1'b0;
  logic         req_valid_i = 1'b0, req_ready_o;
  logic [7:0]   req_client_i = '0, req_source_i = '0, req_ring_i = '0;
  logic [31:0]  req_ctx_i = '0;
  logic         reg_we_i = 1'b0;
  logic [3:0]   reg_addr_i = '0;
  logic [31:0]  reg_wdata_i = '0;
  logic         db_valid_i = 1'b0;
  logic [27:0]  db_addr_i = '0;
  logic [31:0]  db_data_i = '0;
  logic         dma_req_o;
  logic [1:0]   dma_tag_o;
  logic [63:0]  dma_addr_o;
  logic [255:0] dma_data_o;
  logic         dma_ack_i = 1'b0;
  logic [1:0]   dma_ack_tag_i = '0;
  logic         irq_o, err_o;

  int checks = 0, failures = 0;
  logic [31:0] exp_wptr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_ring_writer uut (.*, .clk_i(clk));

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] exp_pkt(input logic [55:0] v);
    logic [255:0] p = '0;
    p[7:0]    = v[55:48];
    p[15:8]   = v[47:40];
    p[23:16]  = v[39:32];
    p[63:32]  = v[31:0];
    p[95:64]  = 32'h40;
    p[111:96] = 16'h8000;
    return p;
  endfunction

  task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk); reg_we_i = 1'b0;
  endtask

  task automatic db_wr(input logic [27:0] a, input logic [31:0] d);
    @(negedge clk); db_valid_i = 1'b1; db_addr_i = a; db_data_i = d;
    @(negedge clk); db_valid_i = 1'b0;
  endtask

  task automatic send(input logic [55:0] v);
    @(negedge clk);
    req_valid_i = 1'b1;
    {req_client_i, req_source_i, req_ring_i, req_ctx_i} = v;
    @(negedge clk); req_valid_i = 1'b0;
  endtask

  task automatic idle_chk(input string req, input int n);
    repeat (n) @(negedge clk);
    chk(req, dma_req_o, 1'b0);
  endtask

  // full three-phase service of one record, offset model kept here
  task automatic serve(input logic [55:0] v);
    logic [31:0] nw;
    for (int k = 0; k < 50 && !dma_req_o; k++) @(negedge clk);
    nw = (exp_wptr + 32 >= RSIZE) ? 32'h0 : exp_wptr + 32;
    chk("R2 pkt req", dma_req_o, 1'b1);
    chk("R2 pkt tag", dma_tag_o, 2'd1);
    chk("R2 pkt addr", dma_addr_o, BASE + 64'(exp_wptr));
    chk("R3 pkt data", dma_data_o, exp_pkt(v));
    dma_ack_i = 1'b1; dma_ack_tag_i = 2'd1;
    @(negedge clk); dma_ack_i = 1'b0;
    chk("R4 ptr tag", dma_tag_o, 2'd2);
    chk("R4 ptr addr", dma_addr_o, SHADOW);
    chk("R9 ptr data", dma_data_o, 256'(nw));
    chk("R5 no early irq", irq_o, 1'b0);
    dma_ack_i = 1'b1; dma_ack_tag_i = 2'd2;
    @(negedge clk); dma_ack_i = 1'b0;
    chk("R5 irq", irq_o, 1'b1);
    chk("R8 idle in irq cycle", dma_req_o, 1'b0);
    @(negedge clk);
    chk("R5 irq one cycle", irq_o, 1'b0);
    exp_wptr = nw;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired act=running exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset req", dma_req_o, 1'b0);
    chk("R1 reset irq", irq_o, 1'b0);
    chk("R1 reset err", err_o, 1'b0);
    chk("R1 reset ready", req_ready_o, 1'b1);
    rst_ni = 1'b1;
    // zero registers: ring size 0 stalls everything
    send(VEC[0]);
    idle_chk("R1 zero regs stall", 4);
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk); rst_ni = 1'b1;
    reg_wr(4'd0, RSIZE);
    reg_wr(4'd1, 32'h0000_1234);
    reg_wr(4'd2, 32'h0000_00AB);
    reg_wr(4'd5, 32'h0000_1000);
    reg_wr(4'd6, 32'h0000_00CD);
    reg_wr(4'd3, 32'h10);
    idle_chk("R1 queue cleared", 5);

    // table walk: timing, layout, wrap
    for (int i = 0; i < NVEC; i++) begin
      send(VEC[i]);
      chk("R2 not early", dma_req_o, 1'b0);
      @(negedge clk);
      chk("R2 due 2 cycles", dma_req_o, 1'b1);
      serve(VEC[i]);
    end
    chk("R9 wrapped offset", exp_wptr, 32'h20);

    // ring full, doorbell release
    reg_wr(4'd3, 32'h40);
    send(VEC[1]);
    idle_chk("R10 stall", 6);
    reg_wr(4'd7, 32'h0000_0005);
    db_wr(28'h14, 32'h0);
    idle_chk("R12 disabled doorbell", 4);
    reg_wr(4'd7, 32'h1C00_0005);
    db_wr(28'h18, 32'h0);
    idle_chk("R12 wrong doorbell addr", 4);
    db_wr(28'h14, 32'h0);
    serve(VEC[1]);

    // register read-offset release
    reg_wr(4'd3, 32'h60);
    send(VEC[2]);
    idle_chk("R11 stall before rptr", 5);
    reg_wr(4'd3, 32'h10);
    serve(VEC[2]);

    // wrong completion tag
    send(VEC[3]);
    for (int k = 0; k < 10 && !dma_req_o; k++) @(negedge clk);
    dma_ack_i = 1'b1; dma_ack_tag_i = 2'd2;
    @(negedge clk); dma_ack_i = 1'b0;
    chk("R6 err pulse", err_o, 1'b1);
    chk("R6 req held", dma_req_o, 1'b1);
    chk("R6 tag held", dma_tag_o, 2'd1);
    @(negedge clk);
    chk("R6 err one cycle", err_o, 1'b0);
    serve(VEC[3]);

    // queue order and backpressure
    for (int i = 0; i < NVEC; i++) send(VEC[i]);
    chk("R7 ready low when full", req_ready_o, 1'b0);
    send(VEC[2]);
    for (int i = 0; i < NVEC; i++) serve(VEC[i]);
    idle_chk("R7 full request dropped", 5);

    // unknown offsets, write-offset register
    reg_wr(4'd9, 32'hFFFF_FFFF);
    reg_wr(4'd15, 32'hFFFF_FFFF);
    reg_wr(4'd4, 32'h40);
    exp_wptr = 32'h40;
    send(VEC[4]);
    serve(VEC[4]);
    chk("R13 offset after set", exp_wptr, 32'h60);

    finish_run();
  end
endmodule